// File: doc/BRIEF.md
# SMBus Alert Interrupt Router

This block takes the active-low SMBus alert pin, which shares a physical pin with general-purpose I/O line 11. It turns an asserted alert into a level request on one of three outputs: a shared PCI-style interrupt line, a system-management interrupt, or a wake request to the power sequencer.

A pin-use select bit decides whether the pin is owned by the GPIO logic or by the alert function. When the GPIO logic owns the pin, the alert is masked. A single SMI enable bit steers an active alert to either the SMI output or the interrupt line. A sleep-state code from the power logic allows a wake request while the system sleeps in states 1 through 4.

The router is level sensitive. Its outputs stay high for as long as the alert is unmasked and the pin is held low, and nothing is latched. A handler stops repeated requests by setting the select bit, servicing the device over SMBus, and clearing the bit again. The raw pin crosses into the clock domain through a synchronizer. The control inputs are already synchronous and act on the next edge.

Top module: `smb_alert_router`

## Requirements
- R1: While rst_ni is low, irq_o, smi_o and wake_o are all 0, even if alert_ni is low.
- R2: A change on alert_ni reaches the outputs on the third rising clock edge after it is sampled, with two synchronizer stages and one output register. After only two edges the outputs do not yet show the change.
- R3: When gpio_sel_i is 1, all three outputs are 0 from the next rising edge on, whatever the level of alert_ni. Clearing the bit while the synchronized pin is low restores the routed output on the next edge.
- R4: With gpio_sel_i = 0, smi_en_i = 1 and the synchronized pin low, smi_o = 1 and irq_o = 0.
- R5: With gpio_sel_i = 0, smi_en_i = 0 and the synchronized pin low, irq_o = 1 and smi_o = 0.
- R6: The routed output stays at 1 on every cycle while alert_ni is held low and unmasked, with no edge latching. It returns to 0 on the third edge after alert_ni returns high.
- R7: wake_o = 1 when the alert is active, unmasked, and sleep_i holds a code from 1 to 4 (S1..S4). wake_o = 0 when sleep_i = 0 (awake). The routed irq_o or smi_o output stays driven in every sleep state.
- R8: sleep_i codes 5, 6 and 7 never produce wake_o, although the routed output still asserts.
- R9: irq_o and smi_o are never 1 in the same cycle.
- R10: Changing smi_en_i while the alert is held low moves the request to the other output on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alert_ni | input | 1 | Raw shared pin, alert active low, asynchronous |
| gpio_sel_i | input | 1 | Pin-use select: 1 = GPIO owns the pin (alert masked), 0 = alert enabled |
| smi_en_i | input | 1 | 1 = route the alert to SMI, 0 = route it to the interrupt line |
| sleep_i | input | 3 | Sleep-state code: 0 awake, 1..4 S1..S4, 5..7 no wake |
| irq_o | output | 1 | Level interrupt request, active high |
| smi_o | output | 1 | Level system-management interrupt request, active high |
| wake_o | output | 1 | Wake request to the power sequencer, active high |

## Verification
The assertions check on every cycle that:
- the two routed outputs are mutually exclusive;
- the select bit clears all outputs one edge later;
- each routed output agrees with the previous cycle's enable bit;
- wake is only ever raised for a legal sleep code;
- any asserted output is backed by a low pin exactly three edges earlier.

Some properties are only shown by the bench's directed scenarios:
- the exact latency in both directions;
- the absence of early assertion after two edges;
- the output being held through long low periods;
- the output being restored after unmasking;
- the full set of sleep codes that do and do not produce wake.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  localparam int unsigned SLEEP_W = 3;
  typedef logic [SLEEP_W-1:0] sleep_t;

  typedef struct packed {
    logic irq;
    logic smi;
    logic wake;
  } alert_out_t;

  localparam alert_out_t ALERT_IDLE = '{irq: 1'b0, smi: 1'b0, wake: 1'b0};

  function automatic logic sleep_in_range(sleep_t s, sleep_t lo, sleep_t hi);
    return (s >= lo) && (s <= hi);
  endfunction
endpackage

// File: rtl/smb_alert_sync.sv
module smb_alert_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= RST_VAL;
        else         chain_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= RST_VAL;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/smb_alert_route.sv
module smb_alert_route
  import smb_alert_pkg::*;
#(
  parameter sleep_t WAKE_LO = 3'd1,
  parameter sleep_t WAKE_HI = 3'd4
) (
  input  logic       active_i,
  input  logic       gpio_sel_i,
  input  logic       smi_en_i,
  input  sleep_t     sleep_i,
  output alert_out_t route_o
);
  logic live;

  assign live = active_i && !gpio_sel_i;

  always_comb begin
    route_o      = ALERT_IDLE;
    route_o.smi  = live && smi_en_i;
    route_o.irq  = live && !smi_en_i;
    route_o.wake = live && sleep_in_range(sleep_i, WAKE_LO, WAKE_HI);
  end
endmodule

// File: rtl/smb_alert_router.sv
module smb_alert_router
  import smb_alert_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter sleep_t      WAKE_LO     = 3'd1,
  parameter sleep_t      WAKE_HI     = 3'd4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           alert_ni,
  input  logic           gpio_sel_i,
  input  logic           smi_en_i,
  input  logic [SLEEP_W-1:0] sleep_i,
  output logic           irq_o,
  output logic           smi_o,
  output logic           wake_o
);
  logic       alert_sync_n;
  alert_out_t route_d, route_q;

  smb_alert_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (alert_ni),
    .q_o    (alert_sync_n)
  );

  smb_alert_route #(.WAKE_LO(WAKE_LO), .WAKE_HI(WAKE_HI)) u_route (
    .active_i   (!alert_sync_n),
    .gpio_sel_i (gpio_sel_i),
    .smi_en_i   (smi_en_i),
    .sleep_i    (sleep_i),
    .route_o    (route_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) route_q <= ALERT_IDLE;
    else         route_q <= route_d;
  end

  assign irq_o  = route_q.irq;
  assign smi_o  = route_q.smi;
  assign wake_o = route_q.wake;
endmodule

// File: rtl/smb_alert_router_chk.sv
module smb_alert_router_chk #(
  parameter int unsigned LAT     = 3,
  parameter logic [2:0]  WAKE_LO = 3'd1,
  parameter logic [2:0]  WAKE_HI = 3'd4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       alert_ni,
  input logic       gpio_sel_i,
  input logic       smi_en_i,
  input logic [2:0] sleep_i,
  input logic       irq_o,
  input logic       smi_o,
  input logic       wake_o
);
  // pin-low history, depth LAT, to bound output timing
  logic [LAT-1:0] low_hist_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_hist_q <= '0;
    else         low_hist_q <= {low_hist_q[LAT-2:0], !alert_ni};
  end

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!irq_o && !smi_o && !wake_o));

  p_pin_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || smi_o || wake_o) |-> low_hist_q[LAT-1]);

  p_mask_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpio_sel_i |=> (!irq_o && !smi_o && !wake_o));

  p_smi_route_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> $past(smi_en_i));

  p_irq_route_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(smi_en_i));

  p_wake_range_r7_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ($past(sleep_i) >= WAKE_LO && $past(sleep_i) <= WAKE_HI));

  p_wake_has_route_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (irq_o || smi_o));

  p_one_route_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && smi_o));
endmodule

bind smb_alert_router smb_alert_router_chk #(
  .LAT     (SYNC_STAGES + 1),
  .WAKE_LO (WAKE_LO),
  .WAKE_HI (WAKE_HI)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .alert_ni   (alert_ni),
  .gpio_sel_i (gpio_sel_i),
  .smi_en_i   (smi_en_i),
  .sleep_i    (sleep_i),
  .irq_o      (irq_o),
  .smi_o      (smi_o),
  .wake_o     (wake_o)
);

// File: tb/smb_alert_router_tb.sv
module smb_alert_router_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alert_n = 1'b1;
  logic       gpio_sel = 1'b0;
  logic       smi_en = 1'b0;
  logic [2:0] sleep = 3'd0;
  logic       irq, smi, wake;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  smb_alert_router dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .alert_ni   (alert_n),
    .gpio_sel_i (gpio_sel),
    .smi_en_i   (smi_en),
    .sleep_i    (sleep),
    .irq_o      (irq),
    .smi_o      (smi),
    .wake_o     (wake)
  );

  // exp = {irq, smi, wake}
  task automatic chk(string req, logic [2:0] exp);
    checks++;
    if ({irq, smi, wake} !== exp) begin
      errors++;
      $display("FAIL %s: actual irq/smi/wake=%b expected=%b at %0t", req, {irq, smi, wake}, exp, $time);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    alert_n = 1'b0;
    edges(3);
    chk("R1 reset with pin low", 3'b000);
    @(negedge clk);
    alert_n = 1'b1;
    rst_n = 1'b1;
    edges(4);
    chk("R1 idle after reset", 3'b000);
  endtask

  task automatic t_irq_latency();
    gpio_sel = 0; smi_en = 0; sleep = 0;
    alert_n = 1'b0;
    edges(2);
    chk("R2 no output after two edges", 3'b000);
    edges(1);
    chk("R2 R5 irq on third edge", 3'b100);
  endtask

  task automatic t_level_hold();
    for (int i = 0; i < 20; i++) begin
      edges(1);
      chk("R6 held while pin low", 3'b100);
    end
    alert_n = 1'b1;
    edges(2);
    chk("R6 still held two edges after release", 3'b100);
    edges(1);
    chk("R6 R2 cleared third edge after release", 3'b000);
  endtask

  task automatic t_smi();
    smi_en = 1'b1;
    alert_n = 1'b0;
    edges(3);
    chk("R4 smi route", 3'b010);
  endtask

  task automatic t_steer();
    smi_en = 1'b0;
    edges(1);
    chk("R10 steer to irq", 3'b100);
    smi_en = 1'b1;
    edges(1);
    chk("R10 steer to smi", 3'b010);
    smi_en = 1'b0;
  endtask

  task automatic t_mask();
    gpio_sel = 1'b1;
    edges(1);
    chk("R3 masked with pin low", 3'b000);
    edges(5);
    chk("R3 stays masked", 3'b000);
    gpio_sel = 1'b0;
    edges(1);
    chk("R3 unmask restores irq", 3'b100);
  endtask

  task automatic t_wake();
    for (int s = 1; s <= 4; s++) begin
      sleep = 3'(s);
      edges(1);
      chk("R7 wake in S1..S4", 3'b101);
    end
    smi_en = 1'b1;
    edges(1);
    chk("R7 wake with smi route", 3'b011);
    smi_en = 1'b0;
    for (int s = 5; s <= 7; s++) begin
      sleep = 3'(s);
      edges(1);
      chk("R8 no wake for codes 5..7", 3'b100);
    end
    sleep = 3'd0;
    edges(1);
    chk("R7 no wake while awake", 3'b100);
    sleep = 3'd3;
    gpio_sel = 1'b1;
    edges(1);
    chk("R3 mask clears wake", 3'b000);
    gpio_sel = 1'b0;
    alert_n = 1'b1;
    edges(3);
    chk("R6 release while asleep", 3'b000);
    sleep = 3'd0;
  endtask

  initial begin
    edges(1);
    t_reset();
    t_irq_latency();
    t_level_hold();
    t_smi();
    t_steer();
    t_mask();
    t_wake();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule